// File: doc/BRIEF.md
# Indexed Word-Load Execution Unit

This block carries out the load-word operation of a small 16-bit RISC coprocessor. It holds eight 16-bit general registers. Register 0 is hard-wired to zero. A decoded instruction is handed over through a start strobe. The instruction carries a mode code, three register selectors (destination, base, index), a 5-bit unsigned offset and a 16-bit immediate.

Four modes read one word from memory through a request/ready read port. These are base plus offset, base plus index, base plus index with post-increment, and base plus index with pre-decrement. The result is written into the destination register, and the index register is adjusted by two where the mode calls for it. The fifth mode loads a 16-bit immediate in two steps: the low byte first, then the high byte.

A separate registered read port lets the surrounding pipeline, or a bench, observe any register. Condition flags are not part of this block, and no mode alters them.

Top module: `ldw_unit`

## Requirements
- R1: Mode code 0 (offset form) reads the word at base register plus zero-extended `offs`, modulo 2^16, and writes it to the destination register.
- R2: Mode code 1 (index form) reads the word at base plus index, modulo 2^16, and leaves the index register unchanged.
- R3: Mode code 2 (post-increment) reads at base plus the old index, and the index register then holds old index plus 2, modulo 2^16.
- R4: Mode code 3 (pre-decrement) reads at base plus (index minus 2), and the index register then holds index minus 2, modulo 2^16.
- R5: When the index selector equals the destination selector in mode 2 or 3, the register ends up holding the loaded word, and the index update is dropped.
- R6: Mode code 4 (immediate) takes two cycles. The first writes `imm[7:0]` into the low byte and keeps the old high byte. The second writes `imm[15:8]` into the high byte and keeps the new low byte. `done` rises on the third negative-edge sample after the start edge.
- R7: For modes 0 to 3, `mem_req` rises two clocks after the accepting edge. It then stays high with a stable `mem_addr` until a cycle with `mem_ready` high.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: `done` is high for exactly one clock after the final register write of an instruction. `busy` is high from acceptance until that write.
- R10: `start` is ignored while `busy` is high. `start` is also ignored when the mode code is 5, 6 or 7: nothing is written and no `done` follows.
- R11: After reset `busy`, `done` and `mem_req` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept an instruction when idle |
| mode | input | 3 | Form code: 0 offset, 1 index, 2 post-increment, 3 pre-decrement, 4 immediate |
| rd_sel | input | 3 | Destination register |
| rb_sel | input | 3 | Base register |
| ri_sel | input | 3 | Index register |
| offs | input | 5 | Unsigned offset for mode 0 |
| imm | input | 16 | Immediate for mode 4 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, taken when `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts and returns the word this cycle |
| peek_sel | input | 3 | Observation register select |
| peek_data | output | 16 | Selected register, one clock later |

## Verification
A corrupted address adder or index path shows up on `mem_addr` on the first cycle of the request. It also shows up in the index register on the first peek after `done`, so a fault surfaces within one instruction. A wrong sequencer state shows as `mem_req` or `done` arriving a cycle early or late, or in the wrong place. A broken byte merge in the immediate form becomes visible in the half-written register value that `peek_data` shows in the `done` cycle. The sweep covers every selector triple in every memory mode, with base values near the top of the address space so that wrap-around is exercised.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  typedef enum logic [2:0] {
    M_OFFS = 3'd0,
    M_IDX  = 3'd1,
    M_POST = 3'd2,
    M_PRE  = 3'd3,
    M_IMM  = 3'd4
  } ldw_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_READ, S_IMM_LO, S_IMM_HI
  } ldw_state_e;

  localparam logic [2:0] MODE_LAST = 3'd4;
endpackage

// File: rtl/ldw_regfile.sv
module ldw_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int NRD  = 3,
  localparam int SW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [SW-1:0]           wsel,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][SW-1:0]  rsel,
  output logic [NRD-1:0][DW-1:0]  rdata,
  input  logic [SW-1:0]           psel,
  output logic [DW-1:0]           pdata
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wsel != '0) begin
      regs[wsel] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (rsel[g] == '0) ? '0 : regs[rsel[g]];
  end

  always_ff @(posedge clk) begin
    if (rst) pdata <= '0;
    else     pdata <= (psel == '0) ? '0 : regs[psel];
  end
endmodule

// File: rtl/ldw_agen.sv
module ldw_agen
  import ldw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int OFFW = 5
) (
  input  ldw_mode_e        mode,
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    idx,
  input  logic [OFFW-1:0]  offs,
  output logic [DW-1:0]    addr,
  output logic [DW-1:0]    idx_next
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  always_comb begin
    case (mode)
      M_POST:  idx_next = idx + STEP;
      M_PRE:   idx_next = idx - STEP;
      default: idx_next = idx;
    endcase
    case (mode)
      M_OFFS:  addr = base + DW'(offs);
      M_PRE:   addr = base + idx_next;
      default: addr = base + idx;
    endcase
  end
endmodule

// File: rtl/ldw_ctrl.sv
module ldw_ctrl
  import ldw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int OFFW = 5,
  localparam int SW  = $clog2(NREG),
  localparam int HW  = DW / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      mode_in,
  input  logic [SW-1:0]   rd_in,
  input  logic [SW-1:0]   rb_in,
  input  logic [SW-1:0]   ri_in,
  input  logic [OFFW-1:0] offs_in,
  input  logic [DW-1:0]   imm_in,
  input  logic [DW-1:0]   agen_addr,
  input  logic [DW-1:0]   agen_idx_next,
  input  logic [DW-1:0]   rd_val,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output ldw_mode_e       mode_q,
  output logic [SW-1:0]   rd_q,
  output logic [SW-1:0]   rb_q,
  output logic [SW-1:0]   ri_q,
  output logic [OFFW-1:0] offs_q,
  output logic            we,
  output logic [SW-1:0]   wsel,
  output logic [DW-1:0]   wdata,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic [DW-1:0]   mem_addr
);
  ldw_state_e    state;
  logic [DW-1:0] imm_q;
  logic          accept;
  logic          idx_mode;

  assign accept   = (state == S_IDLE) && start && (mode_in <= MODE_LAST);
  assign idx_mode = (mode_q == M_POST) || (mode_q == M_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      mode_q   <= M_OFFS;
      rd_q     <= '0;
      rb_q     <= '0;
      ri_q     <= '0;
      offs_q   <= '0;
      imm_q    <= '0;
      mem_addr <= '0;
      done     <= 1'b0;
    end else begin
      done <= ((state == S_READ) && mem_ready) || (state == S_IMM_HI);
      case (state)
        S_IDLE: if (accept) begin
          mode_q <= ldw_mode_e'(mode_in);
          rd_q   <= rd_in;
          rb_q   <= rb_in;
          ri_q   <= ri_in;
          offs_q <= offs_in;
          imm_q  <= imm_in;
          state  <= (mode_in == M_IMM) ? S_IMM_LO : S_FETCH;
        end
        S_FETCH: begin
          mem_addr <= agen_addr;
          state    <= S_READ;
        end
        S_READ:   if (mem_ready) state <= S_IDLE;
        S_IMM_LO: state <= S_IMM_HI;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    we    = 1'b0;
    wsel  = rd_q;
    wdata = '0;
    case (state)
      S_FETCH: begin
        we    = idx_mode && (ri_q != rd_q);
        wsel  = ri_q;
        wdata = agen_idx_next;
      end
      S_READ: begin
        we    = mem_ready;
        wdata = mem_rdata;
      end
      S_IMM_LO: begin
        we    = 1'b1;
        wdata = {rd_val[DW-1:HW], imm_q[HW-1:0]};
      end
      S_IMM_HI: begin
        we    = 1'b1;
        wdata = {imm_q[DW-1:HW], rd_val[HW-1:0]};
      end
      default: ;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign mem_req = (state == S_READ);
endmodule

// File: rtl/ldw_unit.sv
module ldw_unit
  import ldw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int OFFW = 5,
  localparam int SW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic [SW-1:0]   rd_sel,
  input  logic [SW-1:0]   rb_sel,
  input  logic [SW-1:0]   ri_sel,
  input  logic [OFFW-1:0] offs,
  input  logic [DW-1:0]   imm,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic [DW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  input  logic [SW-1:0]   peek_sel,
  output logic [DW-1:0]   peek_data
);
  localparam int NRD = 3;

  ldw_mode_e               mode_q;
  logic [SW-1:0]           rd_q, rb_q, ri_q;
  logic [OFFW-1:0]         offs_q;
  logic                    we;
  logic [SW-1:0]           wsel;
  logic [DW-1:0]           wdata;
  logic [NRD-1:0][SW-1:0]  rsel;
  logic [NRD-1:0][DW-1:0]  rdata;
  logic [DW-1:0]           agen_addr, agen_idx_next;

  assign rsel = {rd_q, ri_q, rb_q};

  ldw_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD)) rf_i (
    .clk(clk), .rst(rst), .we(we), .wsel(wsel), .wdata(wdata),
    .rsel(rsel), .rdata(rdata), .psel(peek_sel), .pdata(peek_data)
  );

  ldw_agen #(.DW(DW), .OFFW(OFFW)) agen_i (
    .mode(mode_q), .base(rdata[0]), .idx(rdata[1]), .offs(offs_q),
    .addr(agen_addr), .idx_next(agen_idx_next)
  );

  ldw_ctrl #(.DW(DW), .NREG(NREG), .OFFW(OFFW)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .mode_in(mode),
    .rd_in(rd_sel), .rb_in(rb_sel), .ri_in(ri_sel), .offs_in(offs), .imm_in(imm),
    .agen_addr(agen_addr), .agen_idx_next(agen_idx_next), .rd_val(rdata[2]),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mode_q(mode_q), .rd_q(rd_q), .rb_q(rb_q), .ri_q(ri_q), .offs_q(offs_q),
    .we(we), .wsel(wsel), .wdata(wdata), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );
endmodule

// File: rtl/ldw_unit_chk.sv
module ldw_unit_chk #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2:0]    mode,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [SW-1:0] peek_sel,
  input logic [DW-1:0] peek_data
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  p_req_busy_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (peek_sel == '0) |=> (peek_data == '0));

  p_bad_mode_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && mode > 3'd4) |=> !busy);
endmodule

bind ldw_unit ldw_unit_chk #(.DW(DW), .SW(SW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
  .peek_sel(peek_sel), .peek_data(peek_data)
);

// File: tb/ldw_unit_tb_top.sv
`timescale 1ns/1ps
module ldw_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  rd_sel = '0, rb_sel = '0, ri_sel = '0, peek_sel = '0;
  logic [4:0]  offs = '0;
  logic [15:0] imm = '0;
  logic        busy, done, mem_req, mem_ready = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0, peek_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [8];

  always #2 clk = ~clk;

  ldw_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .rd_sel(rd_sel),
    .rb_sel(rb_sel), .ri_sel(ri_sel), .offs(offs), .imm(imm), .busy(busy),
    .done(done), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .peek_sel(peek_sel), .peek_data(peek_data)
  );

  function automatic logic [15:0] memf(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C ^ {a[3:0], 12'h000};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(int r, output logic [15:0] v);
    peek_sel = 3'(r);
    tick();
    v = peek_data;
  endtask

  task automatic load_imm(int r, logic [15:0] v);
    int n;
    logic [15:0] mid, fin;
    mid = (r == 0) ? 16'h0 : {model[r][15:8], v[7:0]};
    fin = (r == 0) ? 16'h0 : v;
    peek_sel = 3'(r);
    start = 1'b1; mode = 3'd4; rd_sel = 3'(r); imm = v;
    tick();
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin tick(); n++; end
    chk(n == 3, "R6 immediate latency", 16'(n), 16'd3);
    chk(peek_data == mid, (r == 0) ? "R8 zero reg after low step" : "R6 low step keeps high byte",
        peek_data, mid);
    tick();
    chk(done == 1'b0, "R9 done width", 16'(done), 16'd0);
    chk(peek_data == fin, (r == 0) ? "R8 zero reg after high step" : "R6 final immediate",
        peek_data, fin);
    if (r != 0) model[r] = v;
  endtask

  task automatic mem_op(int md, int rd, int rb, int ri, int off, int lat, bit poke);
    logic [15:0] base, idx, nidx, ea, data, v;
    int n;
    string tg;
    base = model[rb];
    idx  = model[ri];
    case (md)
      0: begin ea = base + 16'(off); nidx = idx; tg = "R1"; end
      1: begin ea = base + idx;      nidx = idx; tg = "R2"; end
      2: begin ea = base + idx;      nidx = idx + 16'd2; tg = "R3"; end
      default: begin nidx = idx - 16'd2; ea = base + nidx; tg = "R4"; end
    endcase
    start = 1'b1; mode = 3'(md); rd_sel = 3'(rd); rb_sel = 3'(rb); ri_sel = 3'(ri);
    offs = 5'(off);
    tick();
    start = 1'b0;
    n = 1;
    while (!mem_req && n < 20) begin tick(); n++; end
    chk(n == 2, "R7 request latency", 16'(n), 16'd2);
    chk(mem_addr == ea, {tg, " address"}, mem_addr, ea);
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin
        start = 1'b1; mode = 3'd4; rd_sel = 3'd7; imm = 16'hDEAD;
      end
      tick();
      start = 1'b0;
      chk(mem_req && mem_addr == ea, "R7 request held", mem_addr, ea);
    end
    data = memf(mem_addr);
    mem_ready = 1'b1; mem_rdata = data;
    tick();
    mem_ready = 1'b0;
    chk(done && !busy, "R9 done after read", {14'd0, done, busy}, 16'h0002);
    if ((md == 2 || md == 3) && ri != rd && ri != 0) model[ri] = nidx;
    if (rd != 0) model[rd] = data;
    peek(rd, v);
    chk(done == 1'b0, "R9 done width", 16'(done), 16'd0);
    chk(v == model[rd], ((md >= 2) && ri == rd) ? "R5 destination wins" : {tg, " destination"},
        v, model[rd]);
    peek(ri, v);
    chk(v == model[ri], ((md >= 2) && ri == rd) ? "R5 index kept" : {tg, " index"},
        v, model[ri]);
  endtask

  initial begin
    #700000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (5) tick();
    rst = 1'b0;
    tick();
    chk(!busy && !done && !mem_req, "R11 reset outputs", {13'd0, busy, done, mem_req}, 16'h0);
    for (int r = 0; r < 8; r++) begin
      peek(r, v);
      chk(v == 16'h0, "R11 reset register", v, 16'h0);
    end

    for (int r = 0; r < 8; r++) begin
      load_imm(r, 16'h8421 ^ 16'(r * 16'h1111));
      load_imm(r, 16'h3C00 + 16'(r * 16'h0107));
    end
    load_imm(0, 16'hBEEF);

    for (int md = 0; md < 4; md++)
      for (int rd = 0; rd < 8; rd++)
        for (int rb = 0; rb < 8; rb++)
          for (int ri = 0; ri < 8; ri++) begin
            load_imm(rb, 16'hFFE0 + 16'(rb * 3 + md));
            load_imm(ri, 16'(ri * 2 + rd * 16));
            mem_op(md, rd, rb, ri, (rd * 7 + rb * 3 + ri) % 32, (rd + rb + ri) % 3, 1'b0);
          end

    load_imm(1, 16'hFFFF);
    mem_op(0, 2, 1, 3, 31, 0, 1'b0);
    load_imm(4, 16'h0000);
    mem_op(3, 5, 1, 4, 0, 1, 1'b0);

    load_imm(7, 16'h1234);
    load_imm(2, 16'h0100);
    load_imm(3, 16'h0004);
    mem_op(2, 6, 2, 3, 0, 2, 1'b1);
    peek(7, v);
    chk(v == 16'h1234, "R10 start while busy ignored", v, 16'h1234);

    for (int m = 5; m < 8; m++) begin
      load_imm(3, 16'h0F0F);
      start = 1'b1; mode = 3'(m); rd_sel = 3'd3; imm = 16'hFFFF;
      tick();
      start = 1'b0;
      chk(!busy, "R10 unknown mode not accepted", 16'(busy), 16'd0);
      tick(); tick();
      chk(!done, "R10 unknown mode no done", 16'(done), 16'd0);
      peek(3, v);
      chk(v == 16'h0F0F, "R10 unknown mode no write", v, 16'h0F0F);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule